// File: doc/BRIEF.md
# MESI Snooping Line Controller

This block tracks the coherence state of every line in one private write-back cache that sits on a shared snooping bus. It follows a write-invalidate discipline. The processor side presents a line address with a read or write flag and holds the request until `cpu_ready` rises. While `cpu_ready` is low the processor is stalled. An upper-level write-through cache forwards each of its writes here as an ordinary write request. A direct-mapped tag and state store sits inside the block. Hit or miss is decided from that store in the cycle the request is presented.

Towards the bus the block raises `bus_req` with a command and a line address. The environment completes the transaction by pulsing `bus_gnt`, and in that same cycle it reports on `bus_shared_in` whether another cache holds the line. Transactions from other caches arrive as one-cycle snoops. The block answers a snoop in the same cycle on `snp_shared`. When a snoop finds a dirty line, or a dirty line has to leave to make room, the block raises `wb_req` with the line address and holds it until `wb_ack`. Moving the data itself is left to the environment.

Controller states:
- IDLE serves hits and snoops.
- EVICT writes back a dirty victim.
- FETCH holds a bus request until grant.
- SNPWB writes back a line demanded by a snoop, then returns to IDLE or FETCH.

Transitions:
- IDLE→EVICT on a miss whose slot holds a Modified line.
- IDLE→FETCH on a clean miss or a write to a Shared line.
- EVICT→FETCH on `wb_ack`.
- FETCH→IDLE on `bus_gnt`.
- IDLE/FETCH→SNPWB on a snoop hitting a Modified line.
- SNPWB→return state on `wb_ack`.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid: no snoop gets a shared response and the first access to any address is a miss.
- R2: A read that hits a Modified, Exclusive or Shared line raises `cpu_ready` in the same cycle with no bus or writeback request, and the line state is unchanged.
- R3: A read miss issues `bus_cmd` 01 (read) at the request address. At grant the line is installed as Exclusive if `bus_shared_in` is low and as Shared if it is high. `cpu_ready` rises in the cycle after the grant.
- R4: A write miss issues `bus_cmd` 10 (read with intent to modify). At grant the line becomes Modified, and `cpu_ready` rises in the next cycle.
- R5: A write hit on Exclusive or Modified raises `cpu_ready` at once with no bus activity and leaves the line Modified. A write hit on Shared first issues `bus_cmd` 11 (invalidate) and then becomes Modified.
- R6: A miss whose slot (the low `IDX_W` address bits) holds a Modified line with another tag first raises `wb_req` with the victim address. The victim becomes Invalid on `wb_ack`, and only then is the bus request raised.
- R7: `snp_shared` is high in the cycle of a snoop exactly when the snooped address holds a valid line.
- R8: A snooped read (`snp_cmd` 01) moves a Modified line to Shared after a writeback of that address. It moves an Exclusive line to Shared and leaves a Shared line Shared.
- R9: A snooped read with intent to modify (10) or invalidate (11) moves a valid line to Invalid. If the line was Modified, a writeback of that address is requested first.
- R10: A snoop takes precedence over a processor request in the same cycle, so `cpu_ready` stays low in that cycle.
- R11: If a pending invalidate upgrade loses its line to a snooped read with intent to modify or invalidate, the pending command becomes read with intent to modify (10).
- R12: `bus_req` with `bus_addr`, and `wb_req` with `wb_addr`, stay asserted and stable until their handshake, except that a snoop may divert a pending bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Line address of the request |
| cpu_ready | output | 1 | Request completes this cycle; low means stall |
| bus_req | output | 1 | Bus transaction request |
| bus_cmd | output | 2 | 00 none, 01 read, 10 read with intent to modify, 11 invalidate |
| bus_addr | output | ADDR_W | Line address of the bus transaction |
| bus_gnt | input | 1 | Transaction completes this cycle |
| bus_shared_in | input | 1 | Another cache holds the line (valid with `bus_gnt`) |
| snp_valid | input | 1 | Transaction from another cache is present |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | This cache holds the snooped line |
| wb_req | output | 1 | Dirty line must be written back |
| wb_addr | output | ADDR_W | Address of the line to write back |
| wb_ack | input | 1 | Writeback done |

## Verification
A wrong line state shows up at the ports at the next access to that line, and no earlier. A state wrongly left valid answers the next snoop with `snp_shared`. A lost Modified mark drops a writeback that should occur. A line left Shared after a write sends a stray invalidate, and Exclusive taken for Shared lets a later write proceed silently. A bench model of each slot's state and tag therefore predicts every port value and cycle of each access and snoop. Randomly mixed operations on a few colliding addresses make stale state surface within a handful of operations.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'b00,
        LN_SHR = 2'b01,
        LN_EXC = 2'b10,
        LN_MOD = 2'b11
    } line_state_e;

    typedef enum logic [1:0] {
        BC_IDLE = 2'b00,
        BC_READ = 2'b01,
        BC_RDX  = 2'b10,
        BC_KILL = 2'b11
    } bus_op_e;

    typedef enum logic [1:0] {
        CTL_IDLE,
        CTL_EVICT,
        CTL_FETCH,
        CTL_SNPWB
    } ctl_state_e;

    typedef enum logic [1:0] {
        ACT_DONE,
        ACT_UPGRADE,
        ACT_FILL_RD,
        ACT_FILL_RDX
    } cpu_act_e;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [TAG_W-1:0]  ra_tag,
    output line_state_e       ra_state,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [TAG_W-1:0]  rb_tag,
    output line_state_e       rb_state,
    input  logic              w_en,
    input  logic [IDX_W-1:0]  w_idx,
    input  logic [TAG_W-1:0]  w_tag,
    input  line_state_e       w_state
);
    localparam int LINES = 1 << IDX_W;

    line_state_e      st_view  [LINES];
    logic [TAG_W-1:0] tag_view [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        line_state_e      st_r;
        logic [TAG_W-1:0] tag_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_r  <= LN_INV;
                tag_r <= '0;
            end else if (w_en && (w_idx == IDX_W'(g))) begin
                st_r  <= w_state;
                tag_r <= w_tag;
            end
        end

        assign st_view[g]  = st_r;
        assign tag_view[g] = tag_r;
    end

    assign ra_state = st_view[ra_idx];
    assign ra_tag   = tag_view[ra_idx];
    assign rb_state = st_view[rb_idx];
    assign rb_tag   = tag_view[rb_idx];

endmodule

// File: rtl/mesi_rules.sv
module mesi_rules
    import mesi_pkg::*;
#(
    parameter int TAG_W = 5
) (
    input  logic             cpu_we,
    input  logic [TAG_W-1:0] cpu_tag,
    input  logic [TAG_W-1:0] ra_tag,
    input  line_state_e      ra_state,
    input  logic             snp_valid,
    input  bus_op_e          snp_op,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic [TAG_W-1:0] rb_tag,
    input  line_state_e      rb_state,
    input  bus_op_e          fill_op,
    input  logic             fill_shared,
    output cpu_act_e         cpu_act,
    output logic             victim_dirty,
    output logic             snp_hit,
    output line_state_e      snp_next,
    output logic             snp_needs_wb,
    output line_state_e      fill_state
);
    logic cpu_hit;

    // Processor side: hit test and the action a request needs
    always_comb begin
        cpu_hit      = (ra_state != LN_INV) && (ra_tag == cpu_tag);
        victim_dirty = !cpu_hit && (ra_state == LN_MOD);
        if (cpu_hit) begin
            if (cpu_we && (ra_state == LN_SHR)) cpu_act = ACT_UPGRADE;
            else                                cpu_act = ACT_DONE;
        end else begin
            cpu_act = cpu_we ? ACT_FILL_RDX : ACT_FILL_RD;
        end
    end

    // Snoop side: what another cache's transaction does to our copy
    always_comb begin
        snp_hit      = snp_valid && (snp_op != BC_IDLE) &&
                       (rb_state != LN_INV) && (rb_tag == snp_tag);
        snp_needs_wb = snp_hit && (rb_state == LN_MOD);
        snp_next     = rb_state;
        unique case (snp_op)
            BC_IDLE: snp_next = rb_state;
            BC_READ: snp_next = (rb_state == LN_INV) ? LN_INV : LN_SHR;
            BC_RDX:  snp_next = LN_INV;
            BC_KILL: snp_next = LN_INV;
        endcase
    end

    // State a line takes when our own transaction completes
    always_comb begin
        if (fill_op == BC_READ) fill_state = fill_shared ? LN_SHR : LN_EXC;
        else                    fill_state = LN_MOD;
    end

endmodule

// File: rtl/mesi_ctrl_fsm.sv
module mesi_ctrl_fsm
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  cpu_act_e          cpu_act,
    input  logic              victim_dirty,
    input  logic [ADDR_W-IDX_W-1:0] victim_tag,
    input  logic              snp_valid,
    input  bus_op_e           snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              snp_hit,
    input  line_state_e       snp_next,
    input  logic              snp_needs_wb,
    input  line_state_e       fill_state,
    input  logic              bus_gnt,
    input  logic              wb_ack,
    output logic              cpu_ready,
    output logic              bus_req,
    output bus_op_e           bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    output bus_op_e           fill_op,
    output logic              st_we,
    output logic [IDX_W-1:0]  st_idx,
    output logic [ADDR_W-IDX_W-1:0] st_tag,
    output line_state_e       st_state
);
    localparam int TAG_W = ADDR_W - IDX_W;

    ctl_state_e        ctl_q, ctl_d, ret_q, ret_d;
    logic [ADDR_W-1:0] pend_q, pend_d, wbq, wbd;
    bus_op_e           pop_q, pop_d;

    logic              snp_kill;
    logic              serve_cpu;

    assign snp_kill  = (snp_op == BC_RDX) || (snp_op == BC_KILL);
    assign serve_cpu = (ctl_q == CTL_IDLE) && cpu_req && !snp_valid;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= CTL_IDLE;
            ret_q  <= CTL_IDLE;
            pend_q <= '0;
            wbq    <= '0;
            pop_q  <= BC_IDLE;
        end else begin
            ctl_q  <= ctl_d;
            ret_q  <= ret_d;
            pend_q <= pend_d;
            wbq    <= wbd;
            pop_q  <= pop_d;
        end
    end

    // Next state
    always_comb begin
        ctl_d  = ctl_q;
        ret_d  = ret_q;
        pend_d = pend_q;
        wbd    = wbq;
        pop_d  = pop_q;
        unique case (ctl_q)
            CTL_IDLE: begin
                if (snp_valid) begin
                    if (snp_needs_wb) begin
                        ctl_d = CTL_SNPWB;
                        ret_d = CTL_IDLE;
                        wbd   = snp_addr;
                    end
                end else if (cpu_req) begin
                    unique case (cpu_act)
                        ACT_DONE: ;
                        ACT_UPGRADE: begin
                            pend_d = cpu_addr;
                            pop_d  = BC_KILL;
                            ctl_d  = CTL_FETCH;
                        end
                        ACT_FILL_RD, ACT_FILL_RDX: begin
                            pend_d = cpu_addr;
                            pop_d  = (cpu_act == ACT_FILL_RDX) ? BC_RDX : BC_READ;
                            if (victim_dirty) begin
                                ctl_d = CTL_EVICT;
                                wbd   = {victim_tag, cpu_addr[IDX_W-1:0]};
                            end else begin
                                ctl_d = CTL_FETCH;
                            end
                        end
                    endcase
                end
            end
            CTL_EVICT: begin
                if (wb_ack) ctl_d = CTL_FETCH;
            end
            CTL_FETCH: begin
                if (snp_valid) begin
                    if (snp_hit && snp_kill && (snp_addr == pend_q) && (pop_q == BC_KILL))
                        pop_d = BC_RDX;
                    if (snp_needs_wb) begin
                        ctl_d = CTL_SNPWB;
                        ret_d = CTL_FETCH;
                        wbd   = snp_addr;
                    end
                end else if (bus_gnt) begin
                    ctl_d = CTL_IDLE;
                end
            end
            CTL_SNPWB: begin
                if (wb_ack) ctl_d = ret_q;
            end
        endcase
    end

    // Outputs and line store update
    always_comb begin
        cpu_ready = serve_cpu && (cpu_act == ACT_DONE);
        bus_req   = (ctl_q == CTL_FETCH);
        bus_op    = bus_req ? pop_q : BC_IDLE;
        bus_addr  = pend_q;
        wb_req    = (ctl_q == CTL_EVICT) || (ctl_q == CTL_SNPWB);
        wb_addr   = wbq;
        fill_op   = pop_q;

        st_we    = 1'b0;
        st_idx   = cpu_addr[IDX_W-1:0];
        st_tag   = cpu_addr[ADDR_W-1:IDX_W];
        st_state = LN_INV;
        if (((ctl_q == CTL_IDLE) || (ctl_q == CTL_FETCH)) && snp_hit) begin
            st_we    = 1'b1;
            st_idx   = snp_addr[IDX_W-1:0];
            st_tag   = snp_addr[ADDR_W-1:IDX_W];
            st_state = snp_next;
        end else if (serve_cpu && (cpu_act == ACT_DONE) && cpu_we) begin
            st_we    = 1'b1;
            st_state = LN_MOD;
        end else if ((ctl_q == CTL_EVICT) && wb_ack) begin
            st_we    = 1'b1;
            st_idx   = wbq[IDX_W-1:0];
            st_tag   = wbq[ADDR_W-1:IDX_W];
            st_state = LN_INV;
        end else if ((ctl_q == CTL_FETCH) && bus_gnt && !snp_valid) begin
            st_we    = 1'b1;
            st_idx   = pend_q[IDX_W-1:0];
            st_tag   = TAG_W'(pend_q[ADDR_W-1:IDX_W]);
            st_state = fill_state;
        end
    end

    // R12: bus request held with a steady address until granted
    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !snp_valid) |=> (bus_req && $stable(bus_addr)));

    // R12: writeback held with a steady address until acknowledged
    assert_wb_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr)));

    // R10: a snoop in the cycle blocks completion of a processor request
    assert_snoop_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !cpu_ready);

    // R6: a victim writeback is followed by the fetch of a different line
    assert_evict_then_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q == CTL_EVICT) && wb_ack) |=> (bus_req && (bus_addr != $past(wb_addr))));

    // R4: after an ownership fill the held write completes next cycle
    assert_rdx_fill_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_req && (bus_op == BC_RDX) && !snp_valid) ##1 (cpu_req && cpu_we && !snp_valid)
        |-> cpu_ready);

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_gnt,
    input  logic              bus_shared_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    input  logic              wb_ack
);
    localparam int TAG_W = ADDR_W - IDX_W;

    bus_op_e          snp_op, bus_op, fill_op;
    logic [TAG_W-1:0] ra_tag, rb_tag, st_tag;
    line_state_e      ra_state, rb_state, snp_next, fill_state, st_state;
    cpu_act_e         cpu_act;
    logic             victim_dirty, snp_hit, snp_needs_wb, st_we;
    logic [IDX_W-1:0] st_idx;

    assign snp_op  = bus_op_e'(snp_cmd);
    assign bus_cmd = bus_op;

    mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ra_idx   (cpu_addr[IDX_W-1:0]),
        .ra_tag   (ra_tag),
        .ra_state (ra_state),
        .rb_idx   (snp_addr[IDX_W-1:0]),
        .rb_tag   (rb_tag),
        .rb_state (rb_state),
        .w_en     (st_we),
        .w_idx    (st_idx),
        .w_tag    (st_tag),
        .w_state  (st_state)
    );

    mesi_rules #(.TAG_W(TAG_W)) u_rules (
        .cpu_we       (cpu_we),
        .cpu_tag      (cpu_addr[ADDR_W-1:IDX_W]),
        .ra_tag       (ra_tag),
        .ra_state     (ra_state),
        .snp_valid    (snp_valid),
        .snp_op       (snp_op),
        .snp_tag      (snp_addr[ADDR_W-1:IDX_W]),
        .rb_tag       (rb_tag),
        .rb_state     (rb_state),
        .fill_op      (fill_op),
        .fill_shared  (bus_shared_in),
        .cpu_act      (cpu_act),
        .victim_dirty (victim_dirty),
        .snp_hit      (snp_hit),
        .snp_next     (snp_next),
        .snp_needs_wb (snp_needs_wb),
        .fill_state   (fill_state)
    );

    mesi_ctrl_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .cpu_addr     (cpu_addr),
        .cpu_act      (cpu_act),
        .victim_dirty (victim_dirty),
        .victim_tag   (ra_tag),
        .snp_valid    (snp_valid),
        .snp_op       (snp_op),
        .snp_addr     (snp_addr),
        .snp_hit      (snp_hit),
        .snp_next     (snp_next),
        .snp_needs_wb (snp_needs_wb),
        .fill_state   (fill_state),
        .bus_gnt      (bus_gnt),
        .wb_ack       (wb_ack),
        .cpu_ready    (cpu_ready),
        .bus_req      (bus_req),
        .bus_op       (bus_op),
        .bus_addr     (bus_addr),
        .wb_req       (wb_req),
        .wb_addr      (wb_addr),
        .fill_op      (fill_op),
        .st_we        (st_we),
        .st_idx       (st_idx),
        .st_tag       (st_tag),
        .st_state     (st_state)
    );

    assign snp_shared = snp_hit;

    // R7: a shared response only ever answers a present snoop
    assert_shared_needs_snoop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        snp_shared |-> snp_valid);

    // R9: a snoop that takes ownership never leaves a writeback pending with a bus grant
    assert_wb_not_with_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> !bus_req);

endmodule

// File: tb/sim_mesi_snoop_ctrl.sv
module sim_mesi_snoop_ctrl;
    localparam int CLK_T = 10;
    localparam int AW = 8;
    localparam int IW = 3;
    localparam int NL = 1 << IW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_req = 0, cpu_we = 0, cpu_ready;
    logic [AW-1:0] cpu_addr = '0, bus_addr, snp_addr = '0, wb_addr;
    logic bus_req, bus_gnt = 0, bus_shared_in = 0;
    logic [1:0] bus_cmd, snp_cmd = 2'b00;
    logic snp_valid = 0, snp_shared, wb_req, wb_ack = 0;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;
    // model: 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified
    int mst [NL];
    int mtg [NL];

    always #(CLK_T/2) clk = ~clk;

    mesi_snoop_ctrl #(.ADDR_W(AW), .IDX_W(IW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_shared(snp_shared),
        .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack));

    task automatic chk(string rq, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic int fill_exp(int op, bit sh);
        if (op == 1) return sh ? 1 : 2;
        return 3;
    endfunction

    function automatic int snoop_exp(int op, int st);
        if (op == 1) return (st == 0) ? 0 : 1;
        return 0;
    endfunction

    task automatic cpu_access(bit we, logic [AW-1:0] a, bit sh);
        int idx = int'(a[IW-1:0]);
        int tg  = int'(a[AW-1:IW]);
        int st  = mst[idx];
        bit hit = (st != 0) && (mtg[idx] == tg);
        int op;
        string rq;
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a;
        #1;
        if (hit && !(we && st == 1)) begin
            rq = we ? "R5" : "R2";
            chk(rq, "hit ready", int'(cpu_ready), 1);
            chk(rq, "hit no bus", int'(bus_req), 0);
            chk(rq, "hit no wb", int'(wb_req), 0);
            @(negedge clk);
            cpu_req = 0;
            if (we) mst[idx] = 3;
            return;
        end
        rq = hit ? "R5" : (we ? "R4" : "R3");
        chk(rq, "stall", int'(cpu_ready), 0);
        if (!hit && st == 3) begin
            @(negedge clk); #1;
            chk("R6", "victim wb_req", int'(wb_req), 1);
            chk("R6", "victim wb_addr", int'(wb_addr), (mtg[idx] << IW) | idx);
            chk("R6", "no bus before wb", int'(bus_req), 0);
            wb_ack = 1;
            @(negedge clk);
            wb_ack = 0;
            mst[idx] = 0;
            #1;
        end else begin
            @(negedge clk); #1;
        end
        op = hit ? 3 : (we ? 2 : 1);
        chk(rq, "bus_req", int'(bus_req), 1);
        chk(rq, "bus_cmd", int'(bus_cmd), op);
        chk(rq, "bus_addr", int'(bus_addr), int'(a));
        if ($urandom % 2 == 1) begin
            @(negedge clk); #1;
            chk("R12", "bus_req held", int'(bus_req), 1);
            chk("R12", "bus_addr held", int'(bus_addr), int'(a));
        end
        bus_gnt = 1; bus_shared_in = sh;
        @(negedge clk);
        bus_gnt = 0; bus_shared_in = 0;
        mst[idx] = fill_exp(op, sh);
        mtg[idx] = tg;
        #1;
        chk(rq, "ready after grant", int'(cpu_ready), 1);
        @(negedge clk);
        cpu_req = 0;
    endtask

    task automatic snoop(int op, logic [AW-1:0] a);
        int idx = int'(a[IW-1:0]);
        int tg  = int'(a[AW-1:IW]);
        int st  = mst[idx];
        bit hit = (st != 0) && (mtg[idx] == tg);
        string rq = (op == 1) ? "R8" : "R9";
        @(negedge clk);
        snp_valid = 1; snp_cmd = 2'(op); snp_addr = a;
        #1;
        chk("R7", "snp_shared", int'(snp_shared), int'(hit));
        @(negedge clk);
        snp_valid = 0; snp_cmd = 2'b00;
        #1;
        if (hit && st == 3) begin
            chk(rq, "snoop wb_req", int'(wb_req), 1);
            chk(rq, "snoop wb_addr", int'(wb_addr), int'(a));
            wb_ack = 1;
            @(negedge clk);
            wb_ack = 0;
            #1;
            chk(rq, "wb released", int'(wb_req), 0);
        end else begin
            chk(rq, "no snoop wb", int'(wb_req), 0);
        end
        if (hit) mst[idx] = snoop_exp(op, st);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(CLK_T * 150000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog R1..: got hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < NL; i++) begin mst[i] = 0; mtg[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state
        chk("R1", "ready", int'(cpu_ready), 0);
        chk("R1", "bus_req", int'(bus_req), 0);
        chk("R1", "wb_req", int'(wb_req), 0);
        snoop(1, 8'h05);
        snoop(2, 8'h2A);
        cpu_access(0, 8'h05, 0);          // R3 miss -> Exclusive
        cpu_access(0, 8'h05, 0);          // R2 hit Exclusive
        cpu_access(1, 8'h05, 0);          // R5 silent E -> M
        cpu_access(1, 8'h05, 0);          // R5 hit M
        cpu_access(0, 8'h05, 0);          // R2 hit M
        snoop(1, 8'h05);                  // R8 M -> S with writeback
        cpu_access(0, 8'h05, 0);          // R2 hit S
        snoop(1, 8'h05);                  // R8 S stays S
        cpu_access(1, 8'h05, 0);          // R5 upgrade via invalidate
        cpu_access(0, 8'h0D, 1);          // R6 evict dirty 0x05, R3 -> S
        snoop(2, 8'h0D);                  // R9 S -> I
        cpu_access(0, 8'h0D, 0);          // R3 miss again -> E
        snoop(1, 8'h0D);                  // R8 E -> S
        cpu_access(1, 8'h13, 0);          // R4 write miss -> M
        snoop(2, 8'h13);                  // R9 M -> I with writeback
        cpu_access(0, 8'h16, 0);
        snoop(3, 8'h16);                  // R9 invalidate on E
        cpu_access(0, 8'h16, 1);

        // R10: snoop and processor request in the same cycle
        cpu_access(0, 8'h21, 0);
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_addr = 8'h21;
        snp_valid = 1; snp_cmd = 2'b01; snp_addr = 8'h02;
        #1;
        chk("R10", "stalled by snoop", int'(cpu_ready), 0);
        chk("R10", "snoop miss shared", int'(snp_shared), 0);
        @(negedge clk);
        snp_valid = 0; snp_cmd = 2'b00;
        #1;
        chk("R10", "ready after snoop", int'(cpu_ready), 1);
        @(negedge clk);
        cpu_req = 0;

        // R11: pending upgrade loses its line to another writer
        cpu_access(0, 8'h37, 1);
        @(negedge clk);
        cpu_req = 1; cpu_we = 1; cpu_addr = 8'h37;
        @(negedge clk); #1;
        chk("R11", "upgrade cmd", int'(bus_cmd), 3);
        snp_valid = 1; snp_cmd = 2'b10; snp_addr = 8'h37;
        #1;
        chk("R11", "snoop sees S", int'(snp_shared), 1);
        @(negedge clk);
        snp_valid = 0; snp_cmd = 2'b00;
        #1;
        chk("R11", "bus_req kept", int'(bus_req), 1);
        chk("R11", "cmd now rdx", int'(bus_cmd), 2);
        bus_gnt = 1;
        @(negedge clk);
        bus_gnt = 0;
        #1;
        chk("R11", "ready after rdx", int'(cpu_ready), 1);
        @(negedge clk);
        cpu_req = 0;
        mst[7] = 3; mtg[7] = 6;
        cpu_access(1, 8'h37, 0);          // R5 hit M, no bus

        // random mix on colliding addresses
        for (int n = 0; n < 400; n++) begin
            int r = int'($urandom % 6);
            logic [AW-1:0] a = AW'((($urandom % 4) << IW) | ($urandom % 4));
            bit sh = bit'($urandom % 2);
            if (r < 2)       cpu_access(0, a, sh);
            else if (r < 4)  cpu_access(1, a, sh);
            else if (r == 4) snoop(1, a);
            else             snoop(2 + int'($urandom % 2), a);
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule